// File: doc/BRIEF.md
# Low Pin Count Memory Cycle Target

This block is the peripheral end of a Low Pin Count memory transaction. It watches a 4-bit multiplexed command/address/data bus and an active-low framing strobe. It recognises the start of a cycle and decodes whether the host wants to read or write one byte. It then gathers a 32-bit address and decides whether that address lies in a window at the very top of the 4 GB space. When it does, the block answers on the same bus with a ready handshake and, for a read, the data byte.

Behind the block sits a plain byte-wide memory port. Reads present an address and take the byte back combinationally. Writes deliver the address and byte on a strobe that lasts one cycle, and this strobe comes only after the bus handshake has finished. A parameter selects the decoded memory size: 256 KB or 512 KB. The size changes both the width of the select window and the number of address bits passed to the memory. Pad tri-stating stays outside the block; it provides an output nibble and an output enable.

Top module: `lpc_mem_target`

## Requirements
- R1: Bus nibbles and the frame strobe are sampled on rising clock edges. A cycle is accepted only if the nibble sampled on the last low-frame clock is 4'b0000. When the frame strobe stays low for several clocks, only the last of those nibbles counts. Any other start nibble leaves the block idle.
- R2: The clock after the start carries the cycle type nibble. Value 4'b010x selects a byte read and 4'b011x selects a byte write; bit 0 is don't-care. Any other value returns the block to idle, with no bus drive and no write strobe.
- R3: The next 8 nibbles carry address bits 31..0, most-significant nibble first. The memory port address is the low ADDR_BITS bits of that address (18 for 256 KB, 19 for 512 KB).
- R4: The target responds only if every address bit from 31 down to ADDR_BITS is 1. For 256 KB that is 0xFFFC0000 to 0xFFFFFFFF; for 512 KB it is 0xFFF80000 to 0xFFFFFFFF.
- R5: For a read, the host drives 2 turnaround clocks after the address. The target then drives, one per clock: 4'b0000 (ready), data bits 3..0, data bits 7..4, 4'b1111, 4'b1111. lad_oe is high exactly on those 5 clocks, the first of which follows the 12th sampled nibble.
- R6: For a write, the data byte follows the address, low nibble first. The host then drives 2 turnaround clocks, and the target drives 4'b0000 followed by two 4'b1111 clocks. After that, mem_we is high for one clock, carrying the address and the byte; this is the clock after the 17th sampled nibble.
- R7: If the address misses the window, lad_oe and mem_we stay low for the whole cycle.
- R8: A low frame strobe at any point abandons the cycle in progress. lad_oe is low on the following clock, no write strobe is given for the abandoned cycle, and the nibble on that clock is judged as a new start.
- R9: While reset is held, lad_oe and mem_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling is on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lframe_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | Nibble sampled from the shared bus |
| lad_out | output | 4 | Nibble the target places on the bus |
| lad_oe | output | 1 | High while the target drives the bus |
| mem_addr | output | ADDR_BITS | Byte address toward the memory |
| mem_rdata | input | 8 | Read byte returned combinationally for mem_addr |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to write |

## Verification
Every result has a fixed distance in clocks from the start nibble. Counting the start as the first sampled nibble, a read drives the ready nibble right after the 12th sampled nibble, and the data and turnaround nibbles follow on the next four clocks. A write drives its ready nibble after the 14th sampled nibble and strobes memory after the 17th. The bench drives one nibble per clock and records the outputs a moment after every rising edge, over 18 clocks per transaction. It then compares the whole recorded trace with masks and nibble sequences computed from those clock counts. An abort at clock k truncates the expected trace at k. A second instance set to 512 KB shares the bus, so addresses that fall only in the wider window show one instance answering and the other silent.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_CTYPE = 4'd1,
        S_ADDR  = 4'd2,
        S_WDATA = 4'd3,
        S_HTAR  = 4'd4,
        S_SYNC  = 4'd5,
        S_RDATA = 4'd6,
        S_TTAR  = 4'd7,
        S_WSTB  = 4'd8
    } tgt_state_e;

    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_READY = 4'h0;
    localparam logic [3:0] NIB_TURN  = 4'hF;
    localparam int         ADDR_NIBS = 8;

    typedef struct packed {
        tgt_state_e  st;
        logic [2:0]  cnt;
        logic        wr;
        logic [31:0] addr;
        logic [7:0]  data;
    } tgt_regs_t;

endpackage

// File: rtl/lpc_addr_window.sv
module lpc_addr_window #(
    parameter int ADDR_BITS = 18
) (
    input  logic [31-ADDR_BITS:0] upper,
    output logic                  hit
);
    localparam int SEL_W = 32 - ADDR_BITS;

    generate
        if (SEL_W > 0) begin : g_sel
            assign hit = &upper[SEL_W-1:0];
        end else begin : g_all
            assign hit = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
    import lpc_tgt_pkg::*;
(
    input  tgt_state_e  st,
    input  logic        phase,
    input  logic [7:0]  data,
    output logic [3:0]  lad_out,
    output logic        lad_oe
);
    always_comb begin
        lad_oe  = 1'b0;
        lad_out = NIB_TURN;
        unique case (st)
            S_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = NIB_READY;
            end
            S_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = phase ? data[7:4] : data[3:0];
            end
            S_TTAR: begin
                lad_oe  = 1'b1;
                lad_out = NIB_TURN;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int MEM_KB = 256
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 lframe_n,
    input  logic [3:0]                           lad_in,
    output logic [3:0]                           lad_out,
    output logic                                 lad_oe,
    output logic [((MEM_KB == 512) ? 19 : 18)-1:0] mem_addr,
    input  logic [7:0]                           mem_rdata,
    output logic                                 mem_we,
    output logic [7:0]                           mem_wdata
);
    localparam int ADDR_BITS = (MEM_KB == 512) ? 19 : 18;
    localparam logic [2:0] LAST_NIB = 3'(ADDR_NIBS - 1);

    tgt_regs_t   r_q, r_d;
    logic [31:0] addr_nxt;
    logic        win_hit;
    logic        unused_hi;

    assign addr_nxt  = {r_q.addr[27:0], lad_in};
    assign unused_hi = ^r_q.addr[31:28];

    lpc_addr_window #(.ADDR_BITS(ADDR_BITS)) u_window (
        .upper (addr_nxt[31:ADDR_BITS]),
        .hit   (win_hit)
    );

    always_comb begin
        r_d = r_q;
        if (!lframe_n) begin
            r_d.st  = (lad_in == NIB_START) ? S_CTYPE : S_IDLE;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                S_IDLE: ;
                S_CTYPE: begin
                    if (lad_in[3:2] == 2'b01) begin
                        r_d.wr  = lad_in[1];
                        r_d.st  = S_ADDR;
                        r_d.cnt = '0;
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end
                S_ADDR: begin
                    r_d.addr = addr_nxt;
                    r_d.cnt  = r_q.cnt + 3'd1;
                    if (r_q.cnt == LAST_NIB) begin
                        r_d.cnt = '0;
                        if (!win_hit)     r_d.st = S_IDLE;
                        else if (r_q.wr)  r_d.st = S_WDATA;
                        else              r_d.st = S_HTAR;
                    end
                end
                S_WDATA: begin
                    if (r_q.cnt[0] == 1'b0) begin
                        r_d.data[3:0] = lad_in;
                        r_d.cnt       = 3'd1;
                    end else begin
                        r_d.data[7:4] = lad_in;
                        r_d.cnt       = '0;
                        r_d.st        = S_HTAR;
                    end
                end
                S_HTAR: begin
                    r_d.cnt = 3'd1;
                    if (r_q.cnt[0]) begin
                        r_d.cnt = '0;
                        r_d.st  = S_SYNC;
                    end
                end
                S_SYNC: begin
                    r_d.cnt = '0;
                    if (r_q.wr) begin
                        r_d.st = S_TTAR;
                    end else begin
                        r_d.data = mem_rdata;
                        r_d.st   = S_RDATA;
                    end
                end
                S_RDATA: begin
                    r_d.cnt = 3'd1;
                    if (r_q.cnt[0]) begin
                        r_d.cnt = '0;
                        r_d.st  = S_TTAR;
                    end
                end
                S_TTAR: begin
                    r_d.cnt = 3'd1;
                    if (r_q.cnt[0]) begin
                        r_d.cnt = '0;
                        r_d.st  = r_q.wr ? S_WSTB : S_IDLE;
                    end
                end
                S_WSTB: r_d.st = S_IDLE;
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    lpc_lad_drive u_drive (
        .st      (r_q.st),
        .phase   (r_q.cnt[0]),
        .data    (r_q.data),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    assign mem_addr  = r_q.addr[ADDR_BITS-1:0];
    assign mem_wdata = r_q.data;
    assign mem_we    = (r_q.st == S_WSTB);

    // R1
    bad_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lframe_n && lad_in != NIB_START) |=> (!lad_oe && !mem_we));

    // R2
    bad_type_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CTYPE && lframe_n && lad_in[3:2] != 2'b01) |=> (r_q.st == S_IDLE));

    // R5
    ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_out == NIB_READY));

    // R6
    strobe_after_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(lad_oe) && $past(lad_out) == NIB_TURN));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ADDR && r_q.cnt == LAST_NIB && lframe_n && !win_hit) |=> (r_q.st == S_IDLE));

    // R8
    frame_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> (!lad_oe && !mem_we));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!lad_oe && !mem_we));
endmodule

// File: tb/lpc_mem_target_bench.sv
`timescale 1ns/1ps
module lpc_mem_target_bench;
    localparam int         NSTEP = 18;
    localparam logic [17:0] RD_OE = 18'h0F800;
    localparam logic [17:0] WR_OE = 18'h0E000;
    localparam logic [17:0] WR_WE = 18'h10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lframe_n = 1'b1;
    logic [3:0]  lad = 4'hF;

    logic [3:0]  s_out, b_out;
    logic        s_oe, b_oe, s_we, b_we;
    logic [17:0] s_addr;
    logic [18:0] b_addr;
    logic [7:0]  s_rdata, b_rdata, s_wdata, b_wdata;

    logic [7:0]  mem    [0:1023];
    logic [7:0]  shadow [0:1023];

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lpc_mem_target #(.MEM_KB(256)) u_lpc_mem_target (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad),
        .lad_out(s_out), .lad_oe(s_oe), .mem_addr(s_addr),
        .mem_rdata(s_rdata), .mem_we(s_we), .mem_wdata(s_wdata));

    lpc_mem_target #(.MEM_KB(512)) u_big (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad),
        .lad_out(b_out), .lad_oe(b_oe), .mem_addr(b_addr),
        .mem_rdata(b_rdata), .mem_we(b_we), .mem_wdata(b_wdata));

    assign s_rdata = mem[s_addr[9:0]];
    assign b_rdata = b_addr[7:0] ^ 8'h5A;

    always @(posedge clk) if (s_we) mem[s_addr[9:0]] <= s_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic lf, input logic [3:0] nib);
        @(negedge clk);
        lframe_n = lf;
        lad = nib;
        @(posedge clk);
        #1;
    endtask

    // Drive one full transaction and compare both instances against expectations.
    task automatic run_cycle(input bit pre_en, input logic [3:0] pre_nib, input logic [3:0] start_nib,
                             input logic [3:0] ctype, input logic [31:0] addr,
                             input logic [7:0] wdata, input int abort_at);
        logic [17:0] s_oev, b_oev, s_wev, b_wev, lim, rd_oe_m, wr_oe_m, wr_we_m;
        logic [3:0]  s_nib [0:NSTEP-1];
        logic [3:0]  b_nib [0:NSTEP-1];
        logic [17:0] s_wa;
        logic [18:0] b_wa;
        logic [7:0]  s_wd, b_wd, exp_s, exp_b;
        bit is_rd, is_wr, acc, s_hit, b_hit;
        string tag;
        s_oev = '0; b_oev = '0; s_wev = '0; b_wev = '0;
        s_wa = '0; b_wa = '0; s_wd = '0; b_wd = '0;
        is_rd = (ctype[3:1] == 3'b010);
        is_wr = (ctype[3:1] == 3'b011);
        acc   = (start_nib == 4'h0) && (abort_at != 0);
        s_hit = &addr[31:18];
        b_hit = &addr[31:19];
        exp_s = shadow[addr[9:0]];
        exp_b = addr[7:0] ^ 8'h5A;
        if (pre_en) step(1'b0, pre_nib);
        for (int i = 0; i < NSTEP; i++) begin
            logic lf;
            logic [3:0] nib;
            lf = 1'b1; nib = 4'hF;
            if (i == abort_at)      begin lf = 1'b0; nib = 4'h5; end
            else if (i > abort_at)  begin lf = 1'b1; nib = 4'hF; end
            else if (i == 0)        begin lf = 1'b0; nib = start_nib; end
            else if (i == 1)        nib = ctype;
            else if (i <= 9)        nib = addr[31-4*(i-2) -: 4];
            else if (is_wr && i == 10) nib = wdata[3:0];
            else if (is_wr && i == 11) nib = wdata[7:4];
            step(lf, nib);
            s_oev[i] = s_oe; b_oev[i] = b_oe; s_wev[i] = s_we; b_wev[i] = b_we;
            s_nib[i] = s_out; b_nib[i] = b_out;
            if (s_we) begin s_wa = s_addr; s_wd = s_wdata; end
            if (b_we) begin b_wa = b_addr; b_wd = b_wdata; end
        end
        lim = (abort_at >= NSTEP) ? '1 : ((18'd1 << abort_at) - 18'd1);
        if (!acc)                     tag = "R1";
        else if (!is_rd && !is_wr)    tag = "R2";
        else if (abort_at < NSTEP)    tag = "R8";
        else if (!s_hit)              tag = "R7";
        else if (is_rd)               tag = "R5";
        else                          tag = "R6";
        rd_oe_m = (acc && is_rd) ? (RD_OE & lim) : '0;
        wr_oe_m = (acc && is_wr) ? (WR_OE & lim) : '0;
        wr_we_m = (acc && is_wr) ? (WR_WE & lim) : '0;
        // main instance, 256 KB window (R4)
        chk(s_oev == (s_hit ? (rd_oe_m | wr_oe_m) : 18'h0), {tag, " oe trace 256K"}, 32'(s_oev),
            32'(s_hit ? (rd_oe_m | wr_oe_m) : 18'h0));
        chk(s_wev == (s_hit ? wr_we_m : 18'h0), {tag, " we trace 256K"}, 32'(s_wev),
            32'(s_hit ? wr_we_m : 18'h0));
        // wide instance, 512 KB window (R4)
        chk(b_oev == (b_hit ? (rd_oe_m | wr_oe_m) : 18'h0), {tag, " R4 oe trace 512K"}, 32'(b_oev),
            32'(b_hit ? (rd_oe_m | wr_oe_m) : 18'h0));
        chk(b_wev == (b_hit ? wr_we_m : 18'h0), {tag, " R4 we trace 512K"}, 32'(b_wev),
            32'(b_hit ? wr_we_m : 18'h0));
        if (acc && is_rd && abort_at >= NSTEP) begin
            if (s_hit)
                chk({s_nib[15], s_nib[14], s_nib[13], s_nib[12], s_nib[11]} ==
                    {4'hF, 4'hF, exp_s[7:4], exp_s[3:0], 4'h0}, "R5 read nibbles 256K",
                    32'({s_nib[15], s_nib[14], s_nib[13], s_nib[12], s_nib[11]}),
                    32'({4'hF, 4'hF, exp_s[7:4], exp_s[3:0], 4'h0}));
            if (b_hit)
                chk({b_nib[15], b_nib[14], b_nib[13], b_nib[12], b_nib[11]} ==
                    {4'hF, 4'hF, exp_b[7:4], exp_b[3:0], 4'h0}, "R5 R3 read nibbles 512K",
                    32'({b_nib[15], b_nib[14], b_nib[13], b_nib[12], b_nib[11]}),
                    32'({4'hF, 4'hF, exp_b[7:4], exp_b[3:0], 4'h0}));
        end
        if (acc && is_wr && abort_at > 16) begin
            if (s_hit) begin
                chk(s_wa == addr[17:0] && s_wd == wdata, "R6 R3 write strobe 256K",
                    {6'h0, s_wa, s_wd}, {6'h0, addr[17:0], wdata});
                shadow[addr[9:0]] = wdata;
            end
            if (b_hit)
                chk(b_wa == addr[18:0] && b_wd == wdata, "R6 R3 write strobe 512K",
                    {5'h0, b_wa, b_wd}, {5'h0, addr[18:0], wdata});
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [3:0]  ct;
        int ab, sel;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'(i) ^ 8'hA5;
            shadow[i] = 8'(i) ^ 8'hA5;
        end
        repeat (4) @(posedge clk);
        #1;
        // R9: quiet during reset
        chk(!s_oe && !s_we && !b_oe && !b_we, "R9 reset outputs", {s_oe, s_we, b_oe, b_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 4'hF);

        // directed corners
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'hFFFC_0010, 8'h00, NSTEP);   // R5 read at window base
        run_cycle(0, 4'h0, 4'h0, 4'h7, 32'hFFFF_FFFF, 8'h3C, NSTEP);   // R6 write at top
        run_cycle(0, 4'h0, 4'h0, 4'h5, 32'hFFFF_FFFF, 8'h00, NSTEP);   // R5 read back
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'hFFFA_0123, 8'h00, NSTEP);   // R4 only 512K answers
        run_cycle(0, 4'h0, 4'h0, 4'h6, 32'hFFFB_FFFF, 8'h77, NSTEP);   // R4 write only 512K
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'h0000_1234, 8'h00, NSTEP);   // R7 miss
        run_cycle(0, 4'h0, 4'h0, 4'h6, 32'h7FFF_FFFF, 8'h11, NSTEP);   // R7 write miss
        run_cycle(0, 4'h0, 4'h3, 4'h4, 32'hFFFF_0000, 8'h00, NSTEP);   // R1 bad start
        run_cycle(1, 4'h0, 4'h5, 4'h4, 32'hFFFF_0000, 8'h00, NSTEP);   // R1 last low clock rejects
        run_cycle(1, 4'h5, 4'h0, 4'h4, 32'hFFFF_0004, 8'h00, NSTEP);   // R1 last low clock accepts
        run_cycle(0, 4'h0, 4'h0, 4'h2, 32'hFFFF_0000, 8'h00, NSTEP);   // R2 bad type
        run_cycle(0, 4'h0, 4'h0, 4'h8, 32'hFFFF_0000, 8'h00, NSTEP);   // R2 bad type
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'hFFFF_0020, 8'h00, 5);       // R8 abort in address
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'hFFFF_0020, 8'h00, NSTEP);   // R8 recovery read
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'hFFFF_0030, 8'h00, 12);      // R8 abort while driving
        run_cycle(0, 4'h0, 4'h0, 4'h6, 32'hFFFF_0040, 8'h99, 15);      // R8 abort before strobe
        run_cycle(0, 4'h0, 4'h0, 4'h4, 32'hFFFF_0040, 8'h00, NSTEP);   // R8 no write landed

        // constrained random
        for (int n = 0; n < 80; n++) begin
            sel = int'($urandom % 8);
            if (sel == 0)      a = $urandom;
            else if (sel == 1) a = {13'h1FFF, 1'b0, 18'($urandom)};
            else               a = {14'h3FFF, 8'($urandom), 10'($urandom)};
            ct = ($urandom % 2 == 0) ? 4'h4 : 4'h6;
            ct[0] = 1'($urandom);
            ab = ($urandom % 8 == 0) ? int'(2 + $urandom % 16) : NSTEP;
            run_cycle(0, 4'h0, 4'h0, ct, a, 8'($urandom), ab);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule